// File: doc/BRIEF.md
# System-Management RAM Window Decoder

This block sits in a chipset host bridge. It decides whether a host memory address falls inside a system-management RAM window and, if it does, redirects the address into a fixed low-memory segment. Software programs the window through three byte-wide configuration registers of function 0. These are a command byte, a base byte and a window-control byte. The host side presents an address and a flag that says the processor is in system-management mode. The block answers at once with a hit flag and the translated address.

The window-control byte carries a three-bit mode field, a visibility bit and the top three base bits. Together with the base byte, these form a megabyte-aligned host base. In the fixed mode the window is a 32 KB region that maps onto itself. In the four relocated modes the window sits at the host base combined with a low segment offset, and it is redirected to that segment. A second copy of the window is decoded one megabyte away.

Top module: `smram_window_decode`

## Requirements
- R1: The host base is {ctl[2:0], base[7:0]} placed at address bits 30:28 and 27:20, with all other bits zero. ctl is the window-control register at configuration offset 0x65. base is the base register at offset 0x64.
- R2: Mode field ctl[7:5] = 0 decodes addresses 0x000E0000 to 0x000E7FFF and maps each onto itself, whatever the host base is.
- R3: Modes 1 and 2 decode a 64 KB window at host base OR 0xB0000 (mode 1) or OR 0xA0000 (mode 2). The window is redirected to 0xB0000 or 0xA0000 respectively.
- R4: Modes 4 and 6 decode a 32 KB window at host base OR 0xA0000 (mode 4) or OR 0xB0000 (mode 6). The window is redirected to 0xA0000 or 0xB0000 respectively.
- R5: In modes 1, 2, 4 and 6 a second window of the same size and target is decoded at the primary window base XOR 0x00100000.
- R6: When the mode is nonzero and the host base is zero, hit stays low for every address.
- R7: Modes 3, 5 and 7 never raise hit.
- R8: When ctl[4] is 1, a window address hits whatever the value of smmActive. When ctl[4] is 0, it hits only while smmActive is 1.
- R9: On a hit, xlatAddr is the target segment OR the in-window offset bits of hostAddr (15 bits for 32 KB, 16 bits for 64 KB). Without a hit, xlatAddr equals hostAddr.
- R10: A write to the command register at offset 0x04 changes only the bits under mask 0x4B. The other bits keep their value, and a read returns the stored byte.
- R11: A configuration read with cfgFunc not 0 returns 0xFF. A write with cfgFunc not 0 changes no register.
- R12: A register write takes effect at the clock edge that samples it, so the address decode in the following cycle already uses the new window.
- R13: After reset all three registers read 0x00. Any other function-0 offset reads 0x00 and ignores writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| cfgFunc | input | 3 | Configuration function number |
| cfgAddr | input | 8 | Configuration register offset |
| cfgWrEn | input | 1 | Configuration write strobe |
| cfgWrData | input | 8 | Configuration write byte |
| cfgRdData | output | 8 | Configuration read byte (combinational) |
| hostAddr | input | 32 | Host memory address |
| smmActive | input | 1 | Processor is in system-management mode |
| hit | output | 1 | Address falls inside a visible window |
| xlatAddr | output | 32 | Translated address |

## Verification
A configuration write and an address decode can fall in the same cycle. The write lands at the clock edge, and the decode right after that edge must already follow the new window. The bench provokes this by changing the mode or base and probing a window address in the cycle directly after the edge. It also lets the primary and alias windows overlap the fixed segment. Each result is judged against a bench model rebuilt from the shadow copy of every accepted write.

// File: rtl/smram_pkg.sv
package smram_pkg;
  localparam logic [7:0] REG_CMD   = 8'h04;
  localparam logic [7:0] REG_BASE  = 8'h64;
  localparam logic [7:0] REG_CTL   = 8'h65;
  localparam logic [7:0] CMD_WMASK = 8'h4B;

  typedef enum logic [1:0] {
    RD_NONE,
    RD_CMD,
    RD_BASE,
    RD_CTL
  } rdSel_e;

  typedef struct packed {
    logic   funcOk;
    logic   wrCmd;
    logic   wrBase;
    logic   wrCtl;
    rdSel_e rdSel;
  } cfgStrobe_t;
endpackage

// File: rtl/smram_cfg_ctrl.sv
module smram_cfg_ctrl
  import smram_pkg::*;
#(
  parameter int FUNC_W = 3,
  parameter int OFFS_W = 8
) (
  input  logic [FUNC_W-1:0] cfgFunc,
  input  logic [OFFS_W-1:0] cfgAddr,
  input  logic              cfgWrEn,
  output cfgStrobe_t        strb
);
  logic funcOk;
  assign funcOk = (cfgFunc == '0);

  always_comb begin
    strb        = '0;
    strb.funcOk = funcOk;
    strb.rdSel  = RD_NONE;
    if (funcOk) begin
      unique case (cfgAddr)
        OFFS_W'(REG_CMD):  begin strb.rdSel = RD_CMD;  strb.wrCmd  = cfgWrEn; end
        OFFS_W'(REG_BASE): begin strb.rdSel = RD_BASE; strb.wrBase = cfgWrEn; end
        OFFS_W'(REG_CTL):  begin strb.rdSel = RD_CTL;  strb.wrCtl  = cfgWrEn; end
        default:           strb.rdSel = RD_NONE;
      endcase
    end
  end
endmodule

// File: rtl/smram_win_match.sv
module smram_win_match #(
  parameter int ADDR_W = 32
) (
  input  logic              winEn,
  input  logic [ADDR_W-1:0] winBase,
  input  logic [ADDR_W-1:0] offMask,
  input  logic [ADDR_W-1:0] hostAddr,
  output logic              match
);
  assign match = winEn && ((hostAddr & ~offMask) == winBase);
endmodule

// File: rtl/smram_window_dp.sv
module smram_window_dp
  import smram_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 8,
  parameter int NUM_WIN = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  cfgStrobe_t        strb,
  input  logic [DATA_W-1:0] wrData,
  output logic [DATA_W-1:0] rdData,
  input  logic [ADDR_W-1:0] hostAddr,
  input  logic              smmActive,
  output logic              hit,
  output logic [ADDR_W-1:0] xlatAddr
);
  localparam logic [ADDR_W-1:0] SEG_A      = ADDR_W'(32'h000A_0000);
  localparam logic [ADDR_W-1:0] SEG_B      = ADDR_W'(32'h000B_0000);
  localparam logic [ADDR_W-1:0] SEG_E      = ADDR_W'(32'h000E_0000);
  localparam logic [ADDR_W-1:0] MASK_32K   = ADDR_W'(32'h0000_7FFF);
  localparam logic [ADDR_W-1:0] MASK_64K   = ADDR_W'(32'h0000_FFFF);
  localparam logic [ADDR_W-1:0] ALIAS_FLIP = ADDR_W'(32'h0010_0000);
  localparam int BASE_LSB = 20;

  logic [DATA_W-1:0] cmdReg, baseReg, ctlReg;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cmdReg  <= '0;
      baseReg <= '0;
      ctlReg  <= '0;
    end else begin
      if (strb.wrCmd)
        cmdReg <= (cmdReg & ~DATA_W'(CMD_WMASK)) | (wrData & DATA_W'(CMD_WMASK));
      if (strb.wrBase) baseReg <= wrData;
      if (strb.wrCtl)  ctlReg  <= wrData;
    end
  end

  always_comb begin
    if (!strb.funcOk) rdData = '1;
    else begin
      unique case (strb.rdSel)
        RD_CMD:  rdData = cmdReg;
        RD_BASE: rdData = baseReg;
        RD_CTL:  rdData = ctlReg;
        default: rdData = '0;
      endcase
    end
  end

  logic [2:0]        mode;
  logic              visOk;
  logic [ADDR_W-1:0] hostBase, priBase, target, offMask;
  logic              priEn, aliEn, baseNonZero;

  assign mode  = ctlReg[7:5];
  assign visOk = ctlReg[4] | smmActive;

  always_comb begin
    hostBase = '0;
    hostBase[BASE_LSB+7:BASE_LSB]     = baseReg;
    hostBase[BASE_LSB+10:BASE_LSB+8]  = ctlReg[2:0];
  end
  assign baseNonZero = (hostBase != '0);

  always_comb begin
    priEn   = 1'b0;
    aliEn   = 1'b0;
    target  = SEG_E;
    offMask = MASK_32K;
    priBase = SEG_E;
    unique case (mode)
      3'd0: begin priEn = 1'b1; end
      3'd1: begin target = SEG_B; offMask = MASK_64K; end
      3'd2: begin target = SEG_A; offMask = MASK_64K; end
      3'd4: begin target = SEG_A; offMask = MASK_32K; end
      3'd6: begin target = SEG_B; offMask = MASK_32K; end
      default: ;
    endcase
    if (mode == 3'd1 || mode == 3'd2 || mode == 3'd4 || mode == 3'd6) begin
      priBase = hostBase | target;
      priEn   = baseNonZero;
      aliEn   = baseNonZero;
    end
  end

  logic [NUM_WIN-1:0] winMatch;

  for (genvar gi = 0; gi < NUM_WIN; gi++) begin : g_win
    logic              en;
    logic [ADDR_W-1:0] wb;
    assign en = (gi == 0) ? priEn : aliEn;
    assign wb = (gi == 0) ? priBase : (priBase ^ ALIAS_FLIP);
    smram_win_match #(.ADDR_W(ADDR_W)) u_match (
      .winEn   (en),
      .winBase (wb),
      .offMask (offMask),
      .hostAddr(hostAddr),
      .match   (winMatch[gi])
    );
  end

  assign hit      = visOk && (winMatch != '0);
  assign xlatAddr = hit ? (target | (hostAddr & offMask)) : hostAddr;

  logic anyWr;
  assign anyWr = strb.wrCmd | strb.wrBase | strb.wrCtl;

  p_hit_vis_r8: assert property (@(posedge clk) disable iff (!rstN)
    hit |-> (smmActive || ctlReg[4]));

  p_reserved_mode_r7: assert property (@(posedge clk) disable iff (!rstN)
    (mode == 3'd3 || mode == 3'd5 || mode == 3'd7) |-> !hit);

  p_zero_base_r6: assert property (@(posedge clk) disable iff (!rstN)
    (mode != 3'd0 && baseReg == '0 && ctlReg[2:0] == 3'd0) |-> !hit);

  p_offset_keep_r9: assert property (@(posedge clk) disable iff (!rstN)
    hit |-> (xlatAddr[14:0] == hostAddr[14:0]));

  p_pass_through_r9: assert property (@(posedge clk) disable iff (!rstN)
    !hit |-> (xlatAddr == hostAddr));

  p_cmd_mask_r10: assert property (@(posedge clk) disable iff (!rstN)
    strb.wrCmd |=> ((cmdReg & ~DATA_W'(CMD_WMASK)) == ($past(cmdReg) & ~DATA_W'(CMD_WMASK))));

  p_regs_hold_r11: assert property (@(posedge clk) disable iff (!rstN)
    !anyWr |=> $stable({cmdReg, baseReg, ctlReg}));
endmodule

// File: rtl/smram_window_decode.sv
module smram_window_decode
  import smram_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 8,
  parameter int FUNC_W = 3,
  parameter int OFFS_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [FUNC_W-1:0] cfgFunc,
  input  logic [OFFS_W-1:0] cfgAddr,
  input  logic              cfgWrEn,
  input  logic [DATA_W-1:0] cfgWrData,
  output logic [DATA_W-1:0] cfgRdData,
  input  logic [ADDR_W-1:0] hostAddr,
  input  logic              smmActive,
  output logic              hit,
  output logic [ADDR_W-1:0] xlatAddr
);
  cfgStrobe_t strb;

  smram_cfg_ctrl #(.FUNC_W(FUNC_W), .OFFS_W(OFFS_W)) u_ctrl (
    .cfgFunc(cfgFunc),
    .cfgAddr(cfgAddr),
    .cfgWrEn(cfgWrEn),
    .strb   (strb)
  );

  smram_window_dp #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .NUM_WIN(2)) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .strb     (strb),
    .wrData   (cfgWrData),
    .rdData   (cfgRdData),
    .hostAddr (hostAddr),
    .smmActive(smmActive),
    .hit      (hit),
    .xlatAddr (xlatAddr)
  );
endmodule

// File: tb/smram_window_decode_bench.sv
module smram_window_decode_bench;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 100000;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [2:0]  cfgFunc = '0;
  logic [7:0]  cfgAddr = '0;
  logic        cfgWrEn = 1'b0;
  logic [7:0]  cfgWrData = '0;
  logic [7:0]  cfgRdData;
  logic [31:0] hostAddr = '0;
  logic        smmActive = 1'b0;
  logic        hit;
  logic [31:0] xlatAddr;

  int nChecks = 0;
  int nFails  = 0;
  bit finished = 0;

  logic [7:0] shCmd = 8'h00, shBase = 8'h00, shCtl = 8'h00;

  always #(CLK_PERIOD/2) clk = ~clk;

  smram_window_decode u_smram_window_decode (
    .clk(clk), .rstN(rstN), .cfgFunc(cfgFunc), .cfgAddr(cfgAddr),
    .cfgWrEn(cfgWrEn), .cfgWrData(cfgWrData), .cfgRdData(cfgRdData),
    .hostAddr(hostAddr), .smmActive(smmActive), .hit(hit), .xlatAddr(xlatAddr)
  );

  function automatic logic [32:0] model(input logic [31:0] a, input logic smm);
    logic [2:0]  m;
    logic [31:0] base, tgt, sz, pri;
    logic        isReloc, h;
    m = shCtl[7:5];
    base = {1'b0, shCtl[2:0], shBase, 20'h0};
    isReloc = 1'b1;
    tgt = 32'h0; sz = 32'h8000;
    case (m)
      3'd1: begin tgt = 32'hB0000; sz = 32'h10000; end
      3'd2: begin tgt = 32'hA0000; sz = 32'h10000; end
      3'd4: begin tgt = 32'hA0000; sz = 32'h8000; end
      3'd6: begin tgt = 32'hB0000; sz = 32'h8000; end
      default: isReloc = 1'b0;
    endcase
    h = 1'b0;
    if (m == 3'd0) begin
      tgt = 32'hE0000;
      h = (a >= 32'hE0000) && (a <= 32'hE7FFF);
    end else if (isReloc && base != 0) begin
      pri = base | tgt;
      h = ((a & ~(sz - 1)) == pri) || ((a & ~(sz - 1)) == (pri ^ 32'h0010_0000));
    end
    h = h && (shCtl[4] || smm);
    if (h) return {1'b1, tgt | (a & (sz - 1))};
    return {1'b0, a};
  endfunction

  task automatic cfgWrite(input logic [2:0] f, input logic [7:0] off, input logic [7:0] d);
    @(negedge clk);
    cfgFunc = f; cfgAddr = off; cfgWrData = d; cfgWrEn = 1'b1;
    @(negedge clk);
    cfgWrEn = 1'b0;
    if (f == 3'd0) begin
      if (off == 8'h04) shCmd = (shCmd & 8'hB4) | (d & 8'h4B);
      else if (off == 8'h64) shBase = d;
      else if (off == 8'h65) shCtl = d;
    end
  endtask

  task automatic cfgReadCheck(input string req, input logic [2:0] f, input logic [7:0] off,
                              input logic [7:0] exp);
    cfgFunc = f; cfgAddr = off;
    #1;
    nChecks++;
    if (cfgRdData !== exp) begin
      nFails++;
      $display("FAIL %s: read f%0d off %02h got %02h expected %02h", req, f, off, cfgRdData, exp);
    end
  endtask

  task automatic addrCheck(input string req, input logic [31:0] a, input logic smm);
    logic [32:0] e;
    hostAddr = a; smmActive = smm;
    #1;
    e = model(a, smm);
    nChecks++;
    if (hit !== e[32] || xlatAddr !== e[31:0]) begin
      nFails++;
      $display("FAIL %s: addr %08h smm %0b got hit %0b xlat %08h expected hit %0b xlat %08h",
               req, a, smm, hit, xlatAddr, e[32], e[31:0]);
    end
  endtask

  task automatic finish();
    if (!finished) begin
      finished = 1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
      $finish;
    end
  endtask

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    nChecks++; nFails++;
    $display("FAIL watchdog: got timeout expected completion");
    finish();
  end

  initial begin
    logic [31:0] pick;
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R13 reset values and unmapped offset
    cfgReadCheck("R13", 3'd0, 8'h04, 8'h00);
    cfgReadCheck("R13", 3'd0, 8'h64, 8'h00);
    cfgReadCheck("R13", 3'd0, 8'h65, 8'h00);
    cfgReadCheck("R13", 3'd0, 8'h10, 8'h00);
    cfgWrite(3'd0, 8'h10, 8'h5A);
    cfgReadCheck("R13", 3'd0, 8'h10, 8'h00);
    // R2 / R8 fixed segment after reset
    addrCheck("R2", 32'h000E0000, 1'b1);
    addrCheck("R2", 32'h000E7FFF, 1'b1);
    addrCheck("R2", 32'h000E8000, 1'b1);
    addrCheck("R8", 32'h000E1234, 1'b0);
    // R10 command mask
    cfgWrite(3'd0, 8'h04, 8'hFF);
    cfgReadCheck("R10", 3'd0, 8'h04, 8'h4B);
    cfgWrite(3'd0, 8'h04, 8'hB4);
    cfgReadCheck("R10", 3'd0, 8'h04, 8'h00);
    // R11 other function
    cfgReadCheck("R11", 3'd3, 8'h65, 8'hFF);
    cfgWrite(3'd1, 8'h65, 8'h30);
    cfgReadCheck("R11", 3'd0, 8'h65, 8'h00);
    addrCheck("R11", 32'h000E0010, 1'b1);
    // R6 zero base with relocated mode
    cfgWrite(3'd0, 8'h65, 8'h30);
    addrCheck("R6", 32'h000B0000, 1'b1);
    addrCheck("R6", 32'h001B0000, 1'b1);
    // R12 base change seen in next cycle, R1/R3/R5
    cfgWrite(3'd0, 8'h64, 8'h12);
    addrCheck("R12", 32'h012B1234, 1'b0);
    addrCheck("R3", 32'h012BFFFF, 1'b0);
    addrCheck("R5", 32'h013B1234, 1'b0);
    addrCheck("R1", 32'h002B1234, 1'b0);
    cfgWrite(3'd0, 8'h65, 8'h45);
    addrCheck("R1", 32'h512A8001, 1'b1);
    addrCheck("R5", 32'h513A8001, 1'b1);
    addrCheck("R8", 32'h512A8001, 1'b0);
    cfgWrite(3'd0, 8'h65, 8'h85);
    addrCheck("R4", 32'h512A7FFF, 1'b1);
    addrCheck("R4", 32'h512A8000, 1'b1);
    cfgWrite(3'd0, 8'h65, 8'hD5);
    addrCheck("R4", 32'h513B0042, 1'b0);
    addrCheck("R9", 32'h513B8042, 1'b0);
    cfgWrite(3'd0, 8'h65, 8'h75);
    addrCheck("R7", 32'h512B0000, 1'b1);
    addrCheck("R7", 32'h000E0000, 1'b1);
    // random mix
    for (int r = 0; r < 60; r++) begin
      cfgWrite(3'd0, 8'h65, 8'($urandom));
      cfgWrite(3'd0, 8'h64, ($urandom_range(0, 3) == 0) ? 8'h00 : 8'($urandom));
      for (int k = 0; k < 16; k++) begin
        pick = {1'b0, shCtl[2:0], shBase, 20'h0};
        case ($urandom_range(0, 4))
          0: pick = pick | 32'hA0000 | 32'($urandom_range(0, 32'h1FFFF));
          1: pick = (pick ^ 32'h100000) | 32'hA0000 | 32'($urandom_range(0, 32'h1FFFF));
          2: pick = 32'hE0000 + 32'($urandom_range(0, 32'h9000));
          3: pick = pick | 32'($urandom_range(32'h90000, 32'hCFFFF));
          default: pick = $urandom;
        endcase
        addrCheck("R9 random", pick, 1'($urandom));
      end
      cfgReadCheck("R13 random", 3'd0, 8'h65, shCtl);
    end
    finish();
  end
endmodule